// File: doc/BRIEF.md
# Misaligned Load Data Aligner

This block sits between a load/store unit and a 32-bit data bus. For every request it forms the address presented to the bus. For loads it also turns the raw bus word into the value written to the destination register. A load at an address that does not match its width is never trapped. A word or unsigned halfword load returns the fetched data rotated. A signed halfword load at an odd address becomes a sign-extended byte load at that exact address.

The bus address is a combinational function of the request, and the bus is expected to return its word in the same cycle. The loaded value passes through one register stage for timing, so it appears one clock after the request together with a valid flag. Byte order on the bus is little-endian: byte lane k holds bits [8k+7:8k]. Stores only have their address aligned; they produce no result.

Top module: `lsalign_load_aligner`

## Requirements
- R1: A word load (kind 2'b00) drives the bus address with bits [1:0] cleared, and its result is the bus word rotated right by 8 × addr[1:0] bits.
- R2: An unsigned halfword load (kind 2'b01) drives the bus address with bit 0 cleared. It takes the halfword in lane pair addr[1] (bits [31:16] when addr[1] is 1, else [15:0]) and zero-extends it. When addr[0] is 1, that 32-bit value is then rotated right by 8.
- R3: A signed halfword load (kind 2'b10) at an even address drives the address unchanged, and its result is the halfword in lane pair addr[1], sign-extended from its bit 15.
- R4: A signed halfword load at an odd address drives the full unaligned address, and its result is the byte in lane addr[1:0], sign-extended from its bit 7.
- R5: An unsigned byte load (kind 2'b11) drives the full address, and its result is the byte in lane addr[1:0], zero-extended.
- R6: A store (req_is_store high) drives the address with bits [1:0] cleared for kind 2'b00, with bit 0 cleared for kinds 2'b01 and 2'b10, and unchanged for kind 2'b11. It never raises result_valid.
- R7: result_valid is high in exactly the cycle after a valid load request. result_data holds its last value whenever no load was accepted in the previous cycle.
- R8: While reset (rst_n low) is asserted, result_valid and result_data are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_kind | input | 2 | 00 word, 01 unsigned halfword, 10 signed halfword, 11 unsigned byte |
| req_addr | input | 32 | Byte address of the access |
| bus_rdata | input | 32 | Word returned by the bus in the request cycle |
| bus_addr | output | 32 | Address presented to the bus |
| result_valid | output | 1 | Loaded value is valid |
| result_data | output | 32 | Aligned and extended load value |

## Verification
A wrong lane choice or rotation amount shows on result_data exactly one clock after the load that used it. It shows only for the offsets and kinds that reach that path, so every kind is swept over all four byte offsets with data whose bytes differ and whose sign bits vary. A wrong address mask shows on bus_addr in the same cycle as the request. A fault in the output register shows as a valid flag or held value that disagrees with the model on the next edge. A fault in the hold path shows after an idle cycle or a store.

// File: rtl/lsalign_pkg.sv
package lsalign_pkg;

    typedef enum logic [1:0] {
        ACC_WORD  = 2'b00,
        ACC_UHALF = 2'b01,
        ACC_SHALF = 2'b10,
        ACC_UBYTE = 2'b11
    } acc_kind_e;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned HALF_W = 16;

endpackage

// File: rtl/lsalign_addr_gen.sv
module lsalign_addr_gen
    import lsalign_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LANES  = 4
) (
    input  logic              is_store,
    input  acc_kind_e         kind,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int unsigned LB = $clog2(LANES);

    logic [ADDR_W-1:0] word_addr;
    logic [ADDR_W-1:0] half_addr;

    assign word_addr = {addr_in[ADDR_W-1:LB], {LB{1'b0}}};
    assign half_addr = {addr_in[ADDR_W-1:1], 1'b0};

    always_comb begin
        addr_out = addr_in;
        unique case (kind)
            ACC_WORD:  addr_out = word_addr;
            ACC_UHALF: addr_out = half_addr;
            // signed halfword: a store aligns, a load keeps the byte address
            ACC_SHALF: addr_out = is_store ? half_addr : addr_in;
            ACC_UBYTE: addr_out = addr_in;
            default:   addr_out = addr_in;
        endcase
    end
endmodule

// File: rtl/lsalign_lane_pick.sv
module lsalign_lane_pick
    import lsalign_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0]              word_in,
    input  logic [$clog2(DATA_W/8)-1:0]    lane,
    output logic [BYTE_W-1:0]              byte_out,
    output logic [HALF_W-1:0]              half_out
);
    localparam int unsigned LANES  = DATA_W / BYTE_W;
    localparam int unsigned HALVES = LANES / 2;
    localparam int unsigned LB     = $clog2(LANES);

    logic [BYTE_W-1:0] bytes_a [LANES];
    logic [HALF_W-1:0] halves_a [HALVES];

    for (genvar k = 0; k < LANES; k++) begin : g_byte
        assign bytes_a[k] = word_in[k*BYTE_W +: BYTE_W];
    end
    for (genvar j = 0; j < HALVES; j++) begin : g_half
        assign halves_a[j] = word_in[j*HALF_W +: HALF_W];
    end

    assign byte_out = bytes_a[lane];
    assign half_out = halves_a[lane[LB-1:1]];
endmodule

// File: rtl/lsalign_rotator.sv
module lsalign_rotator #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0]           din,
    input  logic [$clog2(DATA_W/8)-1:0] amt,
    output logic [DATA_W-1:0]           dout
);
    localparam int unsigned LANES = DATA_W / 8;

    logic [DATA_W-1:0] cand [LANES];

    for (genvar k = 0; k < LANES; k++) begin : g_rot
        if (k == 0) begin : g_zero
            assign cand[k] = din;
        end else begin : g_some
            assign cand[k] = {din[8*k-1:0], din[DATA_W-1:8*k]};
        end
    end

    assign dout = cand[amt];
endmodule

// File: rtl/lsalign_load_aligner.sv
module lsalign_load_aligner
    import lsalign_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_is_store,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              result_valid,
    output logic [DATA_W-1:0] result_data
);
    localparam int unsigned LANES = DATA_W / BYTE_W;
    localparam int unsigned LB    = $clog2(LANES);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } out_state_t;

    out_state_t state_d, state_q;
    acc_kind_e  kind;

    logic [LB-1:0]     lane;
    logic [BYTE_W-1:0] sel_byte;
    logic [HALF_W-1:0] sel_half;
    logic [DATA_W-1:0] word_rot;
    logic [DATA_W-1:0] half_zx;
    logic [DATA_W-1:0] half_rot;
    logic [LB-1:0]     half_amt;
    logic [DATA_W-1:0] load_val;

    assign kind     = acc_kind_e'(req_kind);
    assign lane     = req_addr[LB-1:0];
    assign half_amt = {{(LB-1){1'b0}}, req_addr[0]};
    assign half_zx  = {{(DATA_W-HALF_W){1'b0}}, sel_half};

    lsalign_addr_gen #(.ADDR_W(ADDR_W), .LANES(LANES)) u_addr (
        .is_store (req_is_store),
        .kind     (kind),
        .addr_in  (req_addr),
        .addr_out (bus_addr)
    );

    lsalign_lane_pick #(.DATA_W(DATA_W)) u_pick (
        .word_in  (bus_rdata),
        .lane     (lane),
        .byte_out (sel_byte),
        .half_out (sel_half)
    );

    lsalign_rotator #(.DATA_W(DATA_W)) u_rot_word (
        .din  (bus_rdata),
        .amt  (lane),
        .dout (word_rot)
    );

    lsalign_rotator #(.DATA_W(DATA_W)) u_rot_half (
        .din  (half_zx),
        .amt  (half_amt),
        .dout (half_rot)
    );

    always_comb begin
        load_val = '0;
        unique case (kind)
            ACC_WORD:  load_val = word_rot;
            ACC_UHALF: load_val = half_rot;
            ACC_SHALF: load_val = req_addr[0]
                                ? {{(DATA_W-BYTE_W){sel_byte[BYTE_W-1]}}, sel_byte}
                                : {{(DATA_W-HALF_W){sel_half[HALF_W-1]}}, sel_half};
            ACC_UBYTE: load_val = {{(DATA_W-BYTE_W){1'b0}}, sel_byte};
            default:   load_val = '0;
        endcase

        state_d.valid = req_valid && !req_is_store;
        state_d.data  = state_d.valid ? load_val : state_q.data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign result_valid = state_q.valid;
    assign result_data  = state_q.data;

    // R7
    valid_follows_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $past(req_valid && !req_is_store));

    // R7
    data_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> $stable(result_data));

    // R5
    ubyte_zero_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_store && req_kind == ACC_UBYTE)
        |=> (result_data[DATA_W-1:BYTE_W] == '0));

    // R2
    uhalf_even_zero_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_store && req_kind == ACC_UHALF && !req_addr[0])
        |=> (result_data[DATA_W-1:HALF_W] == '0));

    // R4
    shalf_odd_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_store && req_kind == ACC_SHALF && req_addr[0])
        |=> ((result_data[DATA_W-1:BYTE_W-1] == '0) ||
             (&result_data[DATA_W-1:BYTE_W-1])));

    // R6
    store_word_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_store && req_kind == ACC_WORD)
        |-> (bus_addr[LB-1:0] == '0));

    // R6
    store_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_store) |=> !result_valid);
endmodule

// File: tb/lsalign_load_aligner_test.sv
module lsalign_load_aligner_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_is_store = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [31:0] req_addr = '0;
    logic [31:0] bus_rdata = '0;
    logic [31:0] bus_addr;
    logic        result_valid;
    logic [31:0] result_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic        exp_valid = 1'b0;
    logic [31:0] exp_data  = '0;
    string       exp_tag   = "R8";

    always #10 clk = ~clk;

    lsalign_load_aligner uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_store(req_is_store),
        .req_kind(req_kind), .req_addr(req_addr), .bus_rdata(bus_rdata),
        .bus_addr(bus_addr), .result_valid(result_valid), .result_data(result_data)
    );

    task automatic check32(input string tag, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ror8n(input logic [31:0] v, input int n);
        logic [63:0] dbl;
        dbl = {v, v} >> (8 * n);
        return dbl[31:0];
    endfunction

    function automatic logic [31:0] model_load(input logic [1:0] k, input logic [31:0] a,
                                               input logic [31:0] d);
        logic [15:0] h;
        logic [7:0]  b;
        h = a[1] ? d[31:16] : d[15:0];
        b = d[8*a[1:0] +: 8];
        case (k)
            2'b00:   return ror8n(d, int'(a[1:0]));
            2'b01:   return a[0] ? ror8n({16'h0, h}, 1) : {16'h0, h};
            2'b10:   return a[0] ? 32'($signed(b)) : 32'($signed(h));
            default: return {24'h0, b};
        endcase
    endfunction

    function automatic logic [31:0] model_addr(input logic st, input logic [1:0] k,
                                               input logic [31:0] a);
        if (k == 2'b00) return a & ~32'h3;
        if (k == 2'b01) return a & ~32'h1;
        if (k == 2'b10) return st ? (a & ~32'h1) : a;
        return a;
    endfunction

    function automatic string tag_of(input logic st, input logic [1:0] k, input logic [31:0] a);
        if (st) return "R6";
        case (k)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return a[0] ? "R4" : "R3";
            default: return "R5";
        endcase
    endfunction

    // One bench step: check the outputs of the previous request, then apply a new one.
    task automatic step(input logic v, input logic st, input logic [1:0] k,
                        input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        check32(exp_tag, "result_valid", {31'h0, result_valid}, {31'h0, exp_valid});
        check32(exp_tag, "result_data", result_data, exp_data);
        req_valid = v; req_is_store = st; req_kind = k; req_addr = a; bus_rdata = d;
        #1;
        if (v) check32(tag_of(st, k, a), "bus_addr", bus_addr, model_addr(st, k, a));
        if (v && !st) begin
            exp_valid = 1'b1;
            exp_data  = model_load(k, a, d);
            exp_tag   = tag_of(st, k, a);
        end else begin
            exp_valid = 1'b0;
            exp_tag   = v ? "R6" : "R7";
        end
    endtask

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'hF1E2_8374;
        pats[1] = 32'h1234_5678;
        pats[2] = 32'h80FF_7F01;
        pats[3] = 32'h7F80_0AC3;

        repeat (3) @(negedge clk);
        // R8 reset state
        check32("R8", "result_valid in reset", {31'h0, result_valid}, 32'h0);
        check32("R8", "result_data in reset", result_data, 32'h0);
        rst_n = 1'b1;

        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 4; k++) begin
                for (int off = 0; off < 4; off++) begin
                    for (int st = 0; st < 2; st++) begin
                        step(1'b1, st[0], k[1:0],
                             32'h2000_0100 + 32'(p * 64 + k * 16) + 32'(off), pats[p]);
                    end
                    if (off == 2) step(1'b0, 1'b0, k[1:0], 32'h0, 32'hDEAD_BEEF); // R7 hold
                end
            end
        end
        // R7 back-to-back loads, then idle holds the value
        step(1'b1, 1'b0, 2'b10, 32'h0000_0003, 32'h8000_0000);
        step(1'b1, 1'b0, 2'b01, 32'h0000_0003, 32'hABCD_0000);
        step(1'b0, 1'b0, 2'b00, 32'h0000_0000, 32'h0);
        step(1'b0, 1'b0, 2'b00, 32'h0000_0000, 32'h0);
        @(negedge clk);
        check32(exp_tag, "result_valid final", {31'h0, result_valid}, {31'h0, exp_valid});
        check32(exp_tag, "result_data final", result_data, exp_data);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule